// File: doc/BRIEF.md
# Serial Decimal Field Adder

This engine adds, subtracts or compares two signed decimal numbers that sit in a memory where every word holds one digit. Each number, called a field, is named by the address of its least significant digit. The engine walks from that address toward lower addresses one digit at a time. It stops on the first digit past the starting one whose flag bit is set, because that flag marks the most significant digit. The flag on the starting (least significant) digit carries the sign of the field.

The result replaces field P and keeps P's length. When the operand signs call for a true subtraction and the magnitude of Q is larger, the first pass leaves a ten's complement in memory. A second pass then turns it back into the true magnitude and flips the sign. At the end the engine raises a positive indicator, a zero indicator and an overflow indicator. A separate check indicator reports a parity fault found on any read. The memory port is a single synchronous read/write port with one cycle of read latency.

Top module: `dec_field_adder`

## Requirements
- R1: With op=0 (add) the engine stores P+Q into field P in signed-magnitude form. The sign is held in the flag of the least significant digit, and the flags of the other P digits stay as they were.
- R2: With op=1 (subtract) the engine stores P−Q into field P in the same form.
- R3: With op=2 or op=3 (compare) the engine computes P−Q and sets the indicators, but it never asserts a memory write.
- R4: A field ends at the first flagged digit after its least significant digit, so every field is at least two digits long. The result has exactly the length of P. If Q is shorter, its missing digits count as zero. If Q is longer, its extra digits are ignored.
- R5: When a true subtraction gives a result whose magnitude would be negative, the stored digits are the true magnitude and the stored sign is the inverse of P's sign.
- R6: When the operand magnitudes are added and a carry is left over after P's most significant digit, ind_ovf is set and the stored digits are the sum modulo 10^(length of P). The stored sign stays P's sign.
- R7: ind_zero is set when all result digits are zero, and a zero result keeps P's sign. ind_high is set when the result is nonzero with a positive sign. The two are never set together.
- R8: A memory word is laid out as bit 5 parity, bit 4 flag and bits 3:0 a BCD digit. Every word the engine writes has odd parity over all six bits.
- R9: A read word with even parity stops the operation. ind_chk is set, ind_high, ind_zero and ind_ovf are cleared, and no further writes follow.
- R10: After reset busy, done and all indicators are 0. A start pulse is accepted while the engine is idle and clears the indicators. The indicators are valid when done pulses for exactly one cycle, and they hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted while idle) |
| op | input | 2 | 0 add, 1 subtract, 2 or 3 compare |
| addr_p | input | ADDR_W | Address of P's least significant digit; the result goes here |
| addr_q | input | ADDR_W | Address of Q's least significant digit |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle pulse at the end of an operation |
| ind_high | output | 1 | Result nonzero and positive |
| ind_zero | output | 1 | All result digits zero |
| ind_ovf | output | 1 | Carry out of P's most significant digit on magnitude addition |
| ind_chk | output | 1 | Parity fault seen on a read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd | output | 1 | Read strobe; data returns on mem_rdata one cycle later |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 6 | Write word {parity, flag, digit} |
| mem_rdata | input | 6 | Read word {parity, flag, digit} |

## Verification
Two-digit operands are swept across their whole signed range in coarse steps, for every operation. This covers same-sign and mixed-sign pairs. It separates the magnitude-add path from the true-subtraction path, and inside the latter it separates results that need the recomplement pass from those that do not. Directed cases use unequal field lengths to tell zero-filling of a short Q apart from truncation of a long Q. Carry-out sums, including one that wraps to all zero digits, show that the overflow and zero indicators are independent. A Q word with corrupted parity shows that the operation stops before any write reaches P.

// File: rtl/dfa_pkg.sv
package dfa_pkg;

   typedef struct packed {
      logic       par;
      logic       flag;
      logic [3:0] dig;
   } dfa_word_t;

   typedef enum logic [2:0] {
      S_IDLE, S_RP, S_RQ, S_EX, S_R2, S_X2, S_DONE
   } dfa_state_e;

   localparam logic [1:0] OP_ADD = 2'd0;

   function automatic dfa_word_t mk_word(input logic f, input logic [3:0] d);
      dfa_word_t w;
      w.flag = f;
      w.dig  = d;
      w.par  = ~^{f, d};
      return w;
   endfunction

endpackage

// File: rtl/dfa_par_chk.sv
module dfa_par_chk #(
   parameter bit ENABLE = 1'b1
) (
   input  logic [5:0] word,
   output logic       bad
);
   generate
      if (ENABLE) begin : g_on
         assign bad = ~(^word);
      end else begin : g_off
         logic unused_w;
         assign unused_w = ^word;
         assign bad = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dfa_digit_alu.sv
module dfa_digit_alu (
   input  logic [3:0] a,
   input  logic [3:0] b,
   input  logic       cin,
   input  logic       comp,
   output logic [3:0] sum,
   output logic       cout
);
   logic [3:0] bx;
   logic [4:0] raw;
   logic [4:0] adj;

   always_comb begin
      bx   = comp ? (4'd9 - b) : b;
      raw  = {1'b0, a} + {1'b0, bx} + {4'd0, cin};
      adj  = raw - 5'd10;
      cout = (raw >= 5'd10);
      sum  = cout ? adj[3:0] : raw[3:0];
   end

   // R1
   always_comb begin
      if (a <= 4'd9 && b <= 4'd9)
         digit_range_chk: assert (sum <= 4'd9);
   end
endmodule

// File: rtl/dec_field_adder.sv
module dec_field_adder
   import dfa_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter bit CHECK_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] addr_p,
   input  logic [ADDR_W-1:0] addr_q,
   output logic              busy,
   output logic              done,
   output logic              ind_high,
   output logic              ind_zero,
   output logic              ind_ovf,
   output logic              ind_chk,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_we,
   output logic [5:0]        mem_wdata,
   input  logic [5:0]        mem_rdata
);
   localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   initial begin
      param_range_chk: assert (ADDR_W >= 2 && ADDR_W <= 24)
         else $error("ADDR_W out of range");
   end

   dfa_state_e        state;
   logic [ADDR_W-1:0] pa, qa, pa0;
   logic [1:0]        op_r;
   dfa_word_t         p_word;
   logic              first, q_done, eff_r, carry, sign_p, nz;

   dfa_word_t         qw;
   logic [3:0]        q_dig;
   logic              eff, op_sub, in_rc, ex_err;
   logic [3:0]        alu_a, alu_b, alu_sum;
   logic              alu_cin, alu_comp, alu_cout;
   logic              bad_p, bad_q;
   logic              zero_now, neg;

   dfa_par_chk #(.ENABLE(CHECK_PARITY)) u_chk_p (.word(p_word),   .bad(bad_p));
   dfa_par_chk #(.ENABLE(CHECK_PARITY)) u_chk_q (.word(mem_rdata), .bad(bad_q));

   dfa_digit_alu u_alu (
      .a(alu_a), .b(alu_b), .cin(alu_cin), .comp(alu_comp),
      .sum(alu_sum), .cout(alu_cout)
   );

   always_comb begin
      qw       = dfa_word_t'(mem_rdata);
      op_sub   = (op_r != OP_ADD);
      in_rc    = (state == S_X2);
      q_dig    = q_done ? 4'd0 : qw.dig;
      eff      = first ? (p_word.flag ^ qw.flag ^ op_sub) : eff_r;
      alu_a    = in_rc ? 4'd0 : p_word.dig;
      alu_b    = in_rc ? qw.dig : q_dig;
      alu_comp = in_rc | eff;
      alu_cin  = in_rc ? carry : (first ? eff : carry);
      ex_err   = bad_p | (~q_done & bad_q);
      zero_now = ~(nz | (alu_sum != 4'd0));
      neg      = eff & ~alu_cout;

      mem_addr  = pa;
      mem_rd    = 1'b0;
      mem_we    = 1'b0;
      mem_wdata = '0;
      case (state)
         S_RP: mem_rd = 1'b1;
         S_RQ: begin
            mem_addr = qa;
            mem_rd   = ~q_done;
         end
         S_EX: if (!ex_err && !op_r[1]) begin
            mem_we    = 1'b1;
            mem_wdata = mk_word(p_word.flag, alu_sum);
         end
         S_R2: mem_rd = 1'b1;
         S_X2: if (!bad_q) begin
            mem_we    = 1'b1;
            mem_wdata = mk_word(first ? ~sign_p : qw.flag, alu_sum);
         end
         default: ;
      endcase
   end

   assign busy = (state != S_IDLE);
   assign done = (state == S_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         pa       <= '0;
         qa       <= '0;
         pa0      <= '0;
         op_r     <= '0;
         p_word   <= '0;
         first    <= 1'b0;
         q_done   <= 1'b0;
         eff_r    <= 1'b0;
         carry    <= 1'b0;
         sign_p   <= 1'b0;
         nz       <= 1'b0;
         ind_high <= 1'b0;
         ind_zero <= 1'b0;
         ind_ovf  <= 1'b0;
         ind_chk  <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               pa       <= addr_p;
               pa0      <= addr_p;
               qa       <= addr_q;
               op_r     <= op;
               first    <= 1'b1;
               q_done   <= 1'b0;
               nz       <= 1'b0;
               ind_high <= 1'b0;
               ind_zero <= 1'b0;
               ind_ovf  <= 1'b0;
               ind_chk  <= 1'b0;
               state    <= S_RP;
            end
            S_RP: state <= S_RQ;
            S_RQ: begin
               p_word <= dfa_word_t'(mem_rdata);
               state  <= S_EX;
            end
            S_EX: begin
               if (ex_err) begin
                  ind_chk <= 1'b1;
                  state   <= S_DONE;
               end else begin
                  carry <= alu_cout;
                  eff_r <= eff;
                  first <= 1'b0;
                  if (first) sign_p <= p_word.flag;
                  if (alu_sum != 4'd0) nz <= 1'b1;
                  if (!first && !q_done && qw.flag) q_done <= 1'b1;
                  pa <= pa - ONE;
                  qa <= qa - ONE;
                  if (!first && p_word.flag) begin
                     ind_zero <= zero_now & ~neg;
                     ind_high <= ~(zero_now & ~neg) & ~(sign_p ^ neg);
                     ind_ovf  <= ~eff & alu_cout;
                     if (neg && !op_r[1]) begin
                        pa    <= pa0;
                        carry <= 1'b1;
                        first <= 1'b1;
                        state <= S_R2;
                     end else begin
                        state <= S_DONE;
                     end
                  end else begin
                     state <= S_RP;
                  end
               end
            end
            S_R2: state <= S_X2;
            S_X2: begin
               if (bad_q) begin
                  ind_chk  <= 1'b1;
                  ind_high <= 1'b0;
                  ind_zero <= 1'b0;
                  ind_ovf  <= 1'b0;
                  state    <= S_DONE;
               end else begin
                  carry <= alu_cout;
                  first <= 1'b0;
                  pa    <= pa - ONE;
                  state <= (!first && qw.flag) ? S_DONE : S_R2;
               end
            end
            S_DONE: state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   // R3
   cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_r[1]) |-> !mem_we);

   // R8
   wr_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (^mem_wdata));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   high_zero_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ind_high && ind_zero));

   // R9
   chk_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ind_chk |-> !(ind_high || ind_zero || ind_ovf));

   // R9
   chk_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ind_chk) |-> !mem_we);

endmodule

// File: tb/dec_field_adder_tb_top.sv
module dec_field_adder_tb_top;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    op = 2'd0;
   logic [AW-1:0] addr_p = '0, addr_q = '0;
   logic          busy, done, ind_high, ind_zero, ind_ovf, ind_chk;
   logic [AW-1:0] mem_addr;
   logic          mem_rd, mem_we;
   logic [5:0]    mem_wdata;
   logic [5:0]    mem_rdata = '0;

   logic [5:0]    mem [256];
   logic          tb_we = 1'b0;
   logic [AW-1:0] tb_addr = '0;
   logic [5:0]    tb_data = '0;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   dec_field_adder #(.ADDR_W(AW), .CHECK_PARITY(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .addr_p(addr_p), .addr_q(addr_q), .busy(busy), .done(done),
      .ind_high(ind_high), .ind_zero(ind_zero), .ind_ovf(ind_ovf),
      .ind_chk(ind_chk), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (tb_we) mem[tb_addr] <= tb_data;
      else if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
   end

   function automatic logic [5:0] word_of(input bit f, input int d);
      logic [3:0] dd;
      dd = d[3:0];
      return {~^{f, dd}, f, dd};
   endfunction

   function automatic int pow10(input int n);
      int r = 1;
      for (int i = 0; i < n; i++) r = r * 10;
      return r;
   endfunction

   function automatic logic [5:0] field_word(input int mag, input bit neg,
                                             input int n, input int k);
      bit f;
      f = (k == 0) ? neg : (k == n - 1);
      return word_of(f, (mag / pow10(k)) % 10);
   endfunction

   task automatic poke(input int a, input logic [5:0] w);
      @(negedge clk);
      tb_addr = a[AW-1:0];
      tb_data = w;
      tb_we   = 1'b1;
      @(negedge clk);
      tb_we   = 1'b0;
   endtask

   task automatic put_field(input int a, input int mag, input bit neg, input int n);
      for (int k = 0; k < n; k++) poke(a - k, field_word(mag, neg, n, k));
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic field_check(input int a, input int mag, input bit neg,
                              input int n, input string tag);
      bit ok = 1;
      int bad_k = -1;
      for (int k = 0; k < n; k++)
         if (mem[a - k] !== field_word(mag, neg, n, k)) begin
            ok = 0;
            if (bad_k < 0) bad_k = k;
         end
      check(ok, tag, "field words (R8 layout)",
            ok ? 0 : int'(mem[a - bad_k]),
            ok ? 0 : int'(field_word(mag, neg, n, bad_k)));
   endtask

   task automatic run_op(input int o, input int ap, input int aq);
      int t = 0;
      @(negedge clk);
      op = o[1:0];
      addr_p = ap[AW-1:0];
      addr_q = aq[AW-1:0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && t < 500) begin
         @(negedge clk);
         t++;
      end
      check(done === 1'b1, "R10", "done seen", int'(done), 1);
      @(negedge clk);
      check(done === 1'b0 && busy === 1'b0, "R10", "done one cycle",
            int'({done, busy}), 0);
   endtask

   // full case: P (value,len) at 20, Q (value,len) at 40
   task automatic run_case(input int o, input int p, input int np,
                           input int q, input int nq, input string tag);
      int m, qm, r, mag, qmag;
      bit sgn, zero, high, ovf, pneg;
      m = pow10(np);
      pneg = (p < 0);
      qmag = (q < 0) ? -q : q;
      put_field(20, pneg ? -p : p, pneg, np);
      put_field(40, qmag, q < 0, nq);
      qm = q % m;
      r = (o == 0) ? p + qm : p - qm;
      ovf = (r >= m) || (r <= -m);
      mag = ((r < 0) ? -r : r) % m;
      if (r > 0) sgn = 0;
      else if (r < 0) sgn = 1;
      else sgn = pneg;
      zero = (mag == 0);
      high = !zero && !sgn;
      run_op(o, 20, 40);
      if (o >= 2) field_check(20, pneg ? -p : p, pneg, np, "R3");
      else field_check(20, mag, sgn, np, tag);
      field_check(40, qmag, q < 0, nq, "R3");
      check({ind_high, ind_zero, ind_ovf, ind_chk} === {high, zero, ovf, 1'b0},
            tag, "indicators high,zero,ovf,chk (R7 R6)",
            int'({ind_high, ind_zero, ind_ovf, ind_chk}),
            int'({high, zero, ovf, 1'b0}));
   endtask

   task automatic finish_up;
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000 && !finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
         finish_up();
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = word_of(1'b0, 0);
      repeat (3) @(negedge clk);
      check({busy, done, ind_high, ind_zero, ind_ovf, ind_chk} === 6'b0,
            "R10", "reset state",
            int'({busy, done, ind_high, ind_zero, ind_ovf, ind_chk}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // sweep of two-digit operands: R1 add, R2 subtract, R3 compare, R5, R7
      for (int o = 0; o < 3; o++)
         for (int p = -99; p <= 99; p += 9)
            for (int q = -99; q <= 99; q += 13)
               run_case(o, p, 2, q, 2, (o == 0) ? "R1" : (o == 1) ? "R2" : "R3");

      // R4: short Q zero-filled, long Q truncated
      run_case(0, 123, 3, 45, 2, "R4");
      run_case(0, 12, 2, 987, 3, "R4");
      run_case(1, -5, 3, 7, 2, "R4");
      // R5: recomplement across three digits
      run_case(1, 5, 3, 30, 2, "R5");
      run_case(0, 100, 3, -999, 3, "R5");
      // R6: carry out, including wrap to all zeros
      run_case(0, 60, 2, 70, 2, "R6");
      run_case(0, 50, 2, 50, 2, "R6");
      run_case(1, -80, 2, 45, 2, "R6");
      run_case(3, 55, 2, -66, 2, "R3");
      // R7: zero result keeps P's sign
      run_case(1, -42, 2, -42, 2, "R7");

      // R9: corrupt Q's least significant digit parity
      put_field(20, 37, 0, 2);
      put_field(40, 21, 0, 2);
      poke(40, word_of(1'b0, 1) ^ 6'b100000);
      run_op(0, 20, 40);
      check({ind_high, ind_zero, ind_ovf, ind_chk} === 4'b0001, "R9",
            "indicators on parity fault",
            int'({ind_high, ind_zero, ind_ovf, ind_chk}), 1);
      field_check(20, 37, 0, 2, "R9");
      // indicators held until next start
      repeat (4) @(negedge clk);
      check(ind_chk === 1'b1, "R10", "indicator held", int'(ind_chk), 1);

      finish_up();
   end
endmodule